// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block decides what the data bus returns on a read while the memory's internal programming cycle may still be running. A host that has just written a byte, or a page of bytes, does not need to wait for the worst-case write time. It can read the device repeatedly and watch two status bits to learn when programming has finished.

While the write controller reports busy, any read returns a status word in place of array contents, whatever the address. The polled bit carries the inverse of the most significant bit of the last byte written. The toggle bit changes value once for each separate read access. The remaining bits read as zero. Once busy drops, reads return the array data again. The polled bit then matches the true stored value, and the toggle bit stops changing.

A read is active only while chip enable and output enable are both low. The bus driver enable is brought out as a signal rather than a tristate pin. All inputs are taken as synchronous to the block clock.

Top module: `poll_status_resp`

## Requirements
- R1: `drive_o` is 1 exactly while `ce_ni` and `oe_ni` are both 0, in the same cycle. While `drive_o` is 0, `rd_data_o` is all zeros.
- R2: During a read with `busy_i` = 0, `rd_data_o` equals `array_data_i`.
- R3: During a read with `busy_i` = 1, bit 7 of `rd_data_o` is the inverse of the `wr_bit_i` value captured at the most recent cycle with `wr_en_i` = 1. After reset, that captured value is 0.
- R4: While busy, bit 6 of `rd_data_o` inverts once per read access. The flip happens at the first clock edge of the access, and the bit then holds for the rest of that access, however long it lasts.
- R5: During a read with `busy_i` = 1, bits 5 to 0 of `rd_data_o` are zero.
- R6: During a read with `busy_i` = 1, `rd_data_o` does not depend on `array_data_i`, so a busy read at any address returns the status word.
- R7: A read access that starts while `busy_i` = 0 does not change the toggle bit. The next busy read shows the value one flip away from the last busy read.
- R8: Reset (`rst_ni` = 0) sets the toggle bit to 0 and the captured write bit to 0. The first busy read after reset therefore returns 8'hC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| wr_en_i | input | 1 | One-cycle pulse when a byte is written |
| wr_bit_i | input | 1 | Most significant bit of the byte being written |
| array_data_i | input | 8 | Array contents at the current address |
| rd_data_o | output | 8 | Read data presented to the bus |
| drive_o | output | 1 | Bus driver enable |

## Verification
The assertions assume that `ce_ni`, `oe_ni`, `busy_i` and `wr_en_i` change only between clock edges. The check that a read holds its toggle bit also assumes that `busy_i` stays constant for the whole of that read. The bench drives every input on the falling clock edge. It changes `busy_i` and the write pulse only while no read is in progress, and it returns both enables high between accesses, so that each read counts as a new access.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned POLL_BIT_DEF = 7;
  localparam int unsigned TOG_BIT_DEF  = 6;
endpackage

// File: rtl/poll_read_strobe.sv
module poll_read_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic active_o,
  output logic start_o
);
  logic active_q;

  assign active_o = ~ce_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_o;
  end

  // first cycle of a read access
  assign start_o = active_o & ~active_q;
endmodule

// File: rtl/poll_last_write.sv
module poll_last_write (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic last_bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_bit_o <= 1'b0;
    else if (wr_en_i) last_bit_o <= wr_bit_i;
  end
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tog_o <= 1'b0;
    else if (start_i && busy_i) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/poll_status_resp.sv
module poll_status_resp
  import poll_status_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned POLL_BIT = POLL_BIT_DEF,
  parameter int unsigned TOG_BIT  = TOG_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic              wr_bit_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              drive_o
);
  logic              rd_active;
  logic              rd_start;
  logic              last_bit;
  logic              tog;
  logic [DATA_W-1:0] status_word;

  poll_read_strobe u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .active_o (rd_active),
    .start_o  (rd_start)
  );

  poll_last_write u_last (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_bit_i   (wr_bit_i),
    .last_bit_o (last_bit)
  );

  poll_toggle u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rd_start),
    .busy_i  (busy_i),
    .tog_o   (tog)
  );

  // status word: inverted polled bit, toggle bit, all other bits zero
  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = ~last_bit;
    status_word[TOG_BIT]  = tog;
  end

  assign drive_o   = rd_active;
  assign rd_data_o = !rd_active ? '0 : (busy_i ? status_word : array_data_i);
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              busy_i,
  input logic              wr_en_i,
  input logic              wr_bit_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              drive_o
);
  logic seen_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_bit <= 1'b0;
    else if (wr_en_i) seen_bit <= wr_bit_i;
  end

  p_idle_bus_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (!drive_o && rd_data_o == '0));

  p_read_drives_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni) |-> drive_o);

  p_array_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && !busy_i) |-> rd_data_o == array_data_i);

  p_poll_inverse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && busy_i) |-> rd_data_o[POLL_BIT] == ~seen_bit);

  p_tog_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && $past(drive_o) && $past(drive_o, 2) && busy_i && $past(busy_i))
      |-> $stable(rd_data_o[TOG_BIT]));

  p_reserved_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && busy_i) |-> rd_data_o[TOG_BIT-1:0] == '0);
endmodule

bind poll_status_resp poll_status_chk #(
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT),
  .TOG_BIT  (TOG_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .oe_ni        (oe_ni),
  .busy_i       (busy_i),
  .wr_en_i      (wr_en_i),
  .wr_bit_i     (wr_bit_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o),
  .drive_o      (drive_o)
);

// File: tb/poll_status_resp_bench.sv
`timescale 1ns/1ps
module poll_status_resp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       busy = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_bit = 1'b0;
  logic [7:0] arr = 8'h00;
  logic [7:0] rd_data;
  logic       drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  poll_status_resp u_poll_status_resp (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ce_ni        (ce_n),
    .oe_ni        (oe_n),
    .busy_i       (busy),
    .wr_en_i      (wr_en),
    .wr_bit_i     (wr_bit),
    .array_data_i (arr),
    .rd_data_o    (rd_data),
    .drive_o      (drive)
  );

  // {do_write, write_bit, busy, array, expected}
  typedef struct packed {
    logic       wr;
    logic       wbit;
    logic       busy;
    logic [7:0] arr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 8'hFF, 8'hC0},  // R3 R6: wrote 0, toggle -> 1
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h80},  // R4: toggle -> 0
    '{1'b1, 1'b1, 1'b1, 8'h5A, 8'h40},  // R3: wrote 1, toggle -> 1
    '{1'b0, 1'b0, 1'b0, 8'h5A, 8'h5A},  // R2
    '{1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3},  // R2 R7: idle read, toggle stays 1
    '{1'b0, 1'b0, 1'b1, 8'h12, 8'h00},  // R7 R5: toggle -> 0
    '{1'b1, 1'b1, 1'b0, 8'h80, 8'h80},  // R2: true data after busy
    '{1'b0, 1'b0, 1'b1, 8'h3C, 8'h40}   // R4 R6: toggle -> 1
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // start read at negedge, one rising edge, sample at following negedge
  task automatic begin_read();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_read();
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R8 / R1: reset state
    check8("R1 reset drive", {7'b0, drive}, 8'h00);
    check8("R1 reset data", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: only one enable low -> no read
    ce_n = 1'b0; arr = 8'hA5;
    @(negedge clk);
    check8("R1 ce only drive", {7'b0, drive}, 8'h00);
    check8("R1 ce only data", rd_data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check8("R1 oe only data", rd_data, 8'h00);
    oe_n = 1'b1;
    @(negedge clk);

    // R8: first busy read after reset
    busy = 1'b1;
    begin_read();
    check8("R8 first busy read", rd_data, 8'hC0);
    end_read();
    busy = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].wbit);
      busy = VECS[i].busy;
      arr  = VECS[i].arr;
      begin_read();
      check8($sformatf("R1 vec%0d drive", i), {7'b0, drive}, 8'h01);
      check8($sformatf("R2-R7 vec%0d data", i), rd_data, VECS[i].exp);
      end_read();
    end
    // toggle now 1, last bit 1

    // R4: long busy read holds toggle bit, flips once
    busy = 1'b1; arr = 8'hFF;
    begin_read();
    check8("R4 long read first", rd_data, 8'h00);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check8("R4 long read hold", rd_data, 8'h00);
    end
    // R6: array changes mid-read have no effect
    arr = 8'h7E;
    @(negedge clk);
    check8("R6 array ignored", rd_data, 8'h00);
    end_read();

    // R3: write during busy updates polled bit
    do_write(1'b0);
    begin_read();
    check8("R3 new polled bit", rd_data, 8'hC0);
    end_read();
    busy = 1'b0;
    arr = 8'h33;
    begin_read();
    check8("R2 after busy", rd_data, 8'h33);
    end_read();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule